// File: doc/BRIEF.md
# Legacy Bus Byte Port Slave

This block is a slave on a legacy PC expansion bus. It provides two 8-bit output ports and two 8-bit input ports at two adjacent I/O port numbers. A host write to one of the numbers stores the bus byte in that port's output register. The output register drives the outside pins until the next write to the same number. A host read drives the matching external input byte onto the bus for as long as the command strobe is held.

Every bus pin is sampled by a local clock that runs much faster than the bus. The bus moves address, memory/IO select and status on to the next cycle before it releases the command strobe. For this reason the block freezes its port decode, address bit 0 and both status bits on the first clock where it sees the strobe low. It uses these frozen values for the rest of the cycle. A write is committed only when the strobe is released, using the last data byte that was sampled while the strobe was still low.

Top module: `bus_ioport_slave`

## Requirements
- R1: After reset both output ports read 0x00, `data_oe_o` is low, `data_o` is 0x00 and `sel_fb_no` is high.
- R2: The block acts only when all 16 address bits equal 0x0300 or 0x0301. Address bit 0 selects port 0 (0) or port 1 (1), and any other address causes no port action.
- R3: A cycle with `mio_i` high (memory cycle) causes no port action: no register update, no bus drive and no feedback.
- R4: `s0_ni`=1, `s1_ni`=0 marks a read and `s0_ni`=0, `s1_ni`=1 marks a write. The status pairs 00 and 11 cause no port action.
- R5: The decode, address bit 0 and status are captured at strobe assertion and held. Changing address, `mio_i` or status while the strobe is low does not alter the cycle in progress.
- R6: On a read hit, `data_o` carries the selected input byte and `data_oe_o` is high only while the strobe is seen low. At all other times `data_oe_o` is low and `data_o` is 0x00.
- R7: On a write hit, the output register loads the last byte sampled while the strobe was low, at strobe release and not before. Data that changes at the moment of release is not stored.
- R8: Each output port keeps its last written value. A write to one port leaves the other port unchanged.
- R9: At most one of the four port controls (write 0, read 0, write 1, read 1) is active in any cycle. The frozen {`s1_ni`,`s0_ni`,A0} value selects them as 100, 010, 101 and 011 respectively.
- R10: `sel_fb_no` is driven low while a strobe is in progress whose frozen decode hit. Otherwise it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, much faster than the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus port number |
| mio_i | input | 1 | Memory/IO select, low for I/O cycles |
| s0_ni | input | 1 | Status bit 0, active low |
| s1_ni | input | 1 | Status bit 1, active low |
| cmd_ni | input | 1 | Command strobe, active low |
| data_i | input | 8 | Bus data as seen at the pins |
| data_o | output | 8 | Data driven onto the bus on reads |
| data_oe_o | output | 1 | Bus data driver enable |
| sel_fb_no | output | 1 | Card-selected feedback, active low |
| pin_in0_i | input | 8 | External byte for input port 0 |
| pin_in1_i | input | 8 | External byte for input port 1 |
| port_out0_o | output | 8 | Held byte of output port 0 |
| port_out1_o | output | 8 | Held byte of output port 1 |

## Verification
The bench moves the address, select and status to unrelated values in the middle of an active strobe. A design that decodes live signals would then drop its bus drive or write the wrong port. On every write, the bus data is swapped to the inverted byte at the same moment the strobe is released. A design that commits from the current sample would store the inverted byte, and one that commits at assertion would show the new value while the strobe is still low. Walking-one writes to each port catch a swapped or shared port select. Memory cycles, near-miss addresses with one high or low bit flipped, and the two unused status pairs must leave both ports, the driver enable and the feedback untouched.

// File: rtl/iop_pkg.sv
package iop_pkg;
  localparam int NPORT = 2;

  typedef struct packed {
    logic hit;
    logic s1_n;
    logic s0_n;
    logic a0;
  } cyc_info_t;
endpackage

// File: rtl/iop_sync.sv
module iop_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/iop_decode.sv
module iop_decode #(
  parameter int            AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0300
) (
  input  logic [AW-1:0] addr_i,
  input  logic          mio_i,
  output logic          hit_o,
  output logic          a0_o
);
  // full compare above bit 0; bit 0 picks the port
  assign hit_o = !mio_i && (addr_i[AW-1:1] == BASE[AW-1:1]);
  assign a0_o  = addr_i[0];
endmodule

// File: rtl/iop_ctrl.sv
module iop_ctrl
  import iop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_n_i,
  input  logic             hit_i,
  input  logic             a0_i,
  input  logic             s0_n_i,
  input  logic             s1_n_i,
  input  logic [DW-1:0]    data_i,
  output logic [NPORT-1:0] wr_stb_o,
  output logic [NPORT-1:0] rd_en_o,
  output logic [DW-1:0]    wdata_o,
  output logic             sel_o
);
  logic      cmd_prev_q, active_q;
  logic      fall, rise;
  cyc_info_t held_q;
  logic [DW-1:0] wdata_q;

  assign fall = cmd_prev_q && !cmd_n_i;
  assign rise = !cmd_prev_q && cmd_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_prev_q <= 1'b1;
      active_q   <= 1'b0;
      held_q     <= '0;
      wdata_q    <= '0;
    end else begin
      cmd_prev_q <= cmd_n_i;
      if (fall) begin
        active_q <= 1'b1;
        held_q   <= '{hit: hit_i, s1_n: s1_n_i, s0_n: s0_n_i, a0: a0_i};
      end else if (rise) begin
        active_q <= 1'b0;
      end
      if (!cmd_n_i) wdata_q <= data_i;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_ctl
    assign wr_stb_o[p] = rise && active_q && held_q.hit &&
                         ({held_q.s1_n, held_q.s0_n, held_q.a0} == {2'b10, 1'(p)});
    assign rd_en_o[p]  = !cmd_n_i && active_q && held_q.hit &&
                         ({held_q.s1_n, held_q.s0_n, held_q.a0} == {2'b01, 1'(p)});
  end

  assign wdata_o = wdata_q;
  assign sel_o   = active_q && held_q.hit;

  AST_CTRL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_o, rd_en_o})); // R9
  AST_WR_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> (cmd_n_i && $past(!cmd_n_i))); // R7
  AST_HELD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !cmd_n_i) |=> $stable(held_q)); // R5
endmodule

// File: rtl/iop_ports.sv
module iop_ports
  import iop_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPORT-1:0]         wr_stb_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NPORT-1:0][DW-1:0] out_o
);
  logic [NPORT-1:0][DW-1:0] out_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          out_q[p] <= '0;
      else if (wr_stb_i[p]) out_q[p] <= wdata_i;
    end

    AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_stb_i[p] |=> $stable(out_q[p])); // R8
  end

  assign out_o = out_q;
endmodule

// File: rtl/bus_ioport_slave.sv
module bus_ioport_slave
  import iop_pkg::*;
#(
  parameter int            AW     = 16,
  parameter int            DW     = 8,
  parameter int            STAGES = 2,
  parameter logic [AW-1:0] BASE   = 16'h0300
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          mio_i,
  input  logic          s0_ni,
  input  logic          s1_ni,
  input  logic          cmd_ni,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          sel_fb_no,
  input  logic [DW-1:0] pin_in0_i,
  input  logic [DW-1:0] pin_in1_i,
  output logic [DW-1:0] port_out0_o,
  output logic [DW-1:0] port_out1_o
);
  localparam int BW = 4 + AW + DW;
  localparam logic [BW-1:0] BUS_IDLE = {4'b1111, {AW{1'b0}}, {DW{1'b0}}};

  logic [BW-1:0] bus_s;
  logic          cmd_n_s, mio_s, s1_n_s, s0_n_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          hit, a0, sel;
  logic [NPORT-1:0]         wr_stb, rd_en;
  logic [DW-1:0]            wdata;
  logic [NPORT-1:0][DW-1:0] out_q, pin_in;

  // one chain keeps strobe, control and data aligned
  iop_sync #(.W(BW), .STAGES(STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cmd_ni, mio_i, s1_ni, s0_ni, addr_i, data_i}),
    .q_o (bus_s)
  );
  assign {cmd_n_s, mio_s, s1_n_s, s0_n_s, addr_s, data_s} = bus_s;

  iop_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr_i (addr_s), .mio_i (mio_s), .hit_o (hit), .a0_o (a0)
  );

  iop_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_n_i (cmd_n_s), .hit_i (hit), .a0_i (a0),
    .s0_n_i (s0_n_s), .s1_n_i (s1_n_s), .data_i (data_s),
    .wr_stb_o (wr_stb), .rd_en_o (rd_en), .wdata_o (wdata), .sel_o (sel)
  );

  iop_ports #(.DW(DW)) u_ports (
    .clk_i, .rst_ni, .wr_stb_i (wr_stb), .wdata_i (wdata), .out_o (out_q)
  );

  assign pin_in = {pin_in1_i, pin_in0_i};

  always_comb begin
    data_o = '0;
    for (int p = 0; p < NPORT; p++) if (rd_en[p]) data_o = pin_in[p];
  end

  assign data_oe_o   = |rd_en;
  assign sel_fb_no   = !sel;
  assign port_out0_o = out_q[0];
  assign port_out1_o = out_q[1];

  AST_OE_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !sel_fb_no); // R10
  AST_MEM_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cmd_n_s) && mio_s) |=> sel_fb_no); // R3
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_n_s |-> !data_oe_o); // R6
endmodule

// File: tb/bus_ioport_slave_bench.sv
module bus_ioport_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        mio = 1'b1, s0_n = 1'b1, s1_n = 1'b1, cmd_n = 1'b1;
  logic [7:0]  wdat = '0, in0 = '0, in1 = '0;
  logic [7:0]  data_o, out0, out1;
  logic        oe, fb_n;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp0 = '0, exp1 = '0;
  logic       oe_mid, fb_mid, oe_aft, fb_aft;
  logic [7:0] d_mid, d_aft, p0_mid, p1_mid;

  always #4 clk = ~clk;

  bus_ioport_slave u_bus_ioport_slave (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .mio_i (mio),
    .s0_ni (s0_n), .s1_ni (s1_n), .cmd_ni (cmd_n), .data_i (wdat),
    .data_o (data_o), .data_oe_o (oe), .sel_fb_no (fb_n),
    .pin_in0_i (in0), .pin_in1_i (in1),
    .port_out0_o (out0), .port_out1_o (out1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ports_chk(input string req);
    chk(req, {24'b0, out0}, {24'b0, exp0});
    chk(req, {24'b0, out1}, {24'b0, exp1});
  endtask

  // one bus cycle; chg scrambles address/select/status mid-strobe
  task automatic bus_cycle(input logic [15:0] a, input logic m, input logic s0,
                           input logic s1, input logic [7:0] d, input bit chg);
    @(negedge clk);
    addr = a; mio = m; s0_n = s0; s1_n = s1; wdat = d;
    repeat (2) @(negedge clk);
    cmd_n = 1'b0;
    repeat (6) @(negedge clk);
    if (chg) begin
      addr = ~a; mio = ~m; s0_n = ~s0; s1_n = ~s1;
    end
    repeat (3) @(negedge clk);
    oe_mid = oe; fb_mid = fb_n; d_mid = data_o; p0_mid = out0; p1_mid = out1;
    cmd_n = 1'b1; wdat = ~d;
    repeat (6) @(negedge clk);
    oe_aft = oe; fb_aft = fb_n; d_aft = data_o;
    mio = 1'b1; s0_n = 1'b1; s1_n = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 out0", {24'b0, out0}, 0);
    chk("R1 out1", {24'b0, out1}, 0);
    chk("R1 oe", {31'b0, oe}, 0);
    chk("R1 data", {24'b0, data_o}, 0);
    chk("R1 fb", {31'b0, fb_n}, 1);
  endtask

  task automatic t_write_walk;
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 8; b++) begin
        logic [7:0] v;
        v = 8'(1 << b);
        bus_cycle(16'h0300 + 16'(p), 1'b0, 1'b0, 1'b1, v, 1'b0);
        chk("R7 no early commit", {p1_mid, p0_mid}, {exp1, exp0});
        chk("R6 no drive on write", {31'b0, oe_mid}, 0);
        chk("R10 fb on write hit", {31'b0, fb_mid}, 0);
        if (p == 0) exp0 = v; else exp1 = v;
        ports_chk("R7 R8 R9 walking write");
      end
    end
  endtask

  task automatic t_read;
    in0 = 8'h5A; in1 = 8'hC3;
    bus_cycle(16'h0300, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R6 oe read0", {31'b0, oe_mid}, 1);
    chk("R6 data read0", {24'b0, d_mid}, 32'h5A);
    chk("R10 fb read0", {31'b0, fb_mid}, 0);
    chk("R6 oe after", {31'b0, oe_aft}, 0);
    chk("R6 data after", {24'b0, d_aft}, 0);
    chk("R10 fb after", {31'b0, fb_aft}, 1);
    bus_cycle(16'h0301, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R2 data read1", {24'b0, d_mid}, 32'hC3);
    chk("R6 oe read1", {31'b0, oe_mid}, 1);
    ports_chk("R8 read leaves ports");
  endtask

  task automatic t_hold_decode;
    bus_cycle(16'h0301, 1'b0, 1'b0, 1'b1, 8'h96, 1'b1);
    exp1 = 8'h96;
    ports_chk("R5 held write decode");
    in0 = 8'h3C;
    bus_cycle(16'h0300, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    chk("R5 held read oe", {31'b0, oe_mid}, 1);
    chk("R5 held read data", {24'b0, d_mid}, 32'h3C);
  endtask

  task automatic t_ignore;
    bus_cycle(16'h0300, 1'b1, 1'b0, 1'b1, 8'hEE, 1'b0);
    ports_chk("R3 memory write ignored");
    chk("R3 memory fb", {31'b0, fb_mid}, 1);
    bus_cycle(16'h0301, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R3 memory read oe", {31'b0, oe_mid}, 0);
    bus_cycle(16'h0302, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0);
    ports_chk("R2 addr 0302");
    chk("R2 fb miss", {31'b0, fb_mid}, 1);
    bus_cycle(16'h1300, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0);
    ports_chk("R2 addr 1300");
    bus_cycle(16'h8301, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R2 addr 8301 oe", {31'b0, oe_mid}, 0);
    bus_cycle(16'h0200, 1'b0, 1'b0, 1'b1, 8'h33, 1'b0);
    ports_chk("R2 addr 0200");
    bus_cycle(16'h0300, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0);
    ports_chk("R4 status 00");
    chk("R4 status 00 oe", {31'b0, oe_mid}, 0);
    bus_cycle(16'h0301, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0);
    ports_chk("R4 status 11");
    chk("R4 status 11 oe", {31'b0, oe_mid}, 0);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_walk();
    t_read();
    t_hold_decode();
    t_ignore();
    summary();
  end
endmodule